// File: doc/BRIEF.md
# Floating-Point Round to Bounded Integral

This block takes one IEEE-754 operand, in either single or double precision, and rounds it to an integral value that is still written in the same floating-point format. The rounded value must also fit a signed integer of a chosen width, 32 or 64 bits. Whenever the operand is a NaN or an infinity, or its rounded value falls outside that signed range, the block returns the most negative value of the range, written in the operand's format, and raises the invalid flag. No NaN is passed through, and no result is clamped to the nearer bound.

The rounding direction is either fixed toward zero or taken from a two-bit dynamic mode input. One operation is accepted per clock while `in_valid` is high. The result word and its three flags come out of registers one clock later. Operands are first widened to an internal double layout. The fraction bits below the binary point are then cleared, and a guard bit and a sticky bit decide whether one unit is added at the binary point. Finally the result is narrowed back to the operand's format.

Top module: `fp_round_bounded`

## Requirements
- R1: `fmt_sel` 00 selects single precision, with the operand in `op_bits[31:0]` and the result in `result[31:0]` and `result[63:32]` zero. 01 selects double precision over all 64 bits. 10 and 11 raise `undef`, clear `inexact` and `invalid`, and give a zero result word.
- R2: With `use_dyn` low, rounding is toward zero whatever `dyn_mode` holds.
- R3: With `use_dyn` high, `dyn_mode` picks the direction: 00 to nearest with ties to even, 01 toward +infinity, 10 toward -infinity, 11 toward zero.
- R4: A zero operand of either sign returns the same zero and raises no flag.
- R5: `inexact` is high exactly when a valid result differs numerically from the operand. It is never high together with `invalid`.
- R6: A NaN, quiet or signalling, or an infinite operand returns -2^(N-1) encoded in the operand's format and raises `invalid`. N is 64 when `int64_sel` is 1 and 32 when it is 0.
- R7: A finite operand whose rounded value lies outside [-2^(N-1), 2^(N-1)-1] returns -2^(N-1) in the operand's format and raises `invalid`. -2^(N-1) itself is in range.
- R8: A non-zero operand that rounds to zero returns a zero carrying the operand's sign, and denormal operands are rounded by their true value.
- R9: An operand that is already integral and in range is returned bit for bit with no flag raised.
- R10: `out_valid` goes high on the clock edge after the one that samples `in_valid` high. Result and flags change only on an edge that samples `in_valid` high.
- R11: While reset is asserted and until the first accepted operation, `out_valid`, `result`, `inexact`, `invalid` and `undef` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation present this cycle |
| op_bits | input | 64 | Operand word (single in bits 31:0) |
| fmt_sel | input | 2 | Format: 00 single, 01 double, 1x illegal |
| int64_sel | input | 1 | Integer range: 0 is 32-bit, 1 is 64-bit |
| use_dyn | input | 1 | 0 rounds toward zero, 1 uses `dyn_mode` |
| dyn_mode | input | 2 | Dynamic rounding direction |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Rounded value in the operand's format |
| inexact | output | 1 | Result differs from the operand |
| invalid | output | 1 | NaN, infinity or out-of-range operand |
| undef | output | 1 | Illegal format select |

## Verification
Every result and flag is due on the first rising edge after the operands are presented with `in_valid` high. No combinational path reaches the outputs. The bench drives each operation on a falling edge and drops `in_valid` on the next falling edge. It reads `out_valid`, `result` and all three flags at that point, half a cycle after the capturing edge. After an idle cycle it reads the outputs again to confirm that `out_valid` has fallen and the result has held.

// File: rtl/rbi_pkg.sv
package rbi_pkg;
  localparam int DEXP  = 11;
  localparam int DFRAC = 52;
  localparam int DBIAS = 1023;
  localparam int SEXP  = 8;
  localparam int SFRAC = 23;
  localparam int SBIAS = 127;
  localparam int WORD  = 1 + DEXP + DFRAC;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_UP        = 2'b01,
    RM_DOWN      = 2'b10,
    RM_ZERO      = 2'b11
  } rmode_e;

  typedef struct packed {
    logic zero;
    logic special;
  } op_class_t;
endpackage

// File: rtl/rbi_widen.sv
module rbi_widen
  import rbi_pkg::*;
#(
  parameter int WEXP  = DEXP,
  parameter int WFRAC = DFRAC,
  parameter int WBIAS = DBIAS,
  parameter int NEXP  = SEXP,
  parameter int NFRAC = SFRAC,
  parameter int NBIAS = SBIAS
) (
  input  logic [WEXP+WFRAC:0] op_bits,
  input  logic                is_single,
  output logic                sign,
  output logic [WEXP-1:0]     exp_w,
  output logic [WFRAC-1:0]    frac_w,
  output op_class_t           cls
);
  localparam int NW     = 1 + NEXP + NFRAC;
  localparam int REBIAS = WBIAS - NBIAS;

  logic [NEXP-1:0]  n_exp;
  logic [NFRAC-1:0] n_frac;

  assign n_exp  = op_bits[NW-2 -: NEXP];
  assign n_frac = op_bits[NFRAC-1:0];

  always_comb begin
    if (is_single) begin
      sign   = op_bits[NW-1];
      frac_w = {n_frac, {(WFRAC-NFRAC){1'b0}}};
      if (&n_exp) begin
        exp_w = '1;
      end else if (n_exp == '0) begin
        // a narrow denormal is far below one half: any tiny exponent rounds alike
        exp_w = (n_frac == '0) ? '0 : WEXP'(REBIAS);
      end else begin
        exp_w = WEXP'(n_exp) + WEXP'(REBIAS);
      end
    end else begin
      sign   = op_bits[WEXP+WFRAC];
      exp_w  = op_bits[WEXP+WFRAC-1 -: WEXP];
      frac_w = op_bits[WFRAC-1:0];
    end
    cls.zero    = (exp_w == '0) && (frac_w == '0);
    cls.special = &exp_w;
  end
endmodule

// File: rtl/rbi_round_core.sv
module rbi_round_core
  import rbi_pkg::*;
#(
  parameter int WEXP       = DEXP,
  parameter int WFRAC      = DFRAC,
  parameter int WBIAS      = DBIAS,
  parameter int INT_WIDE   = 64,
  parameter int INT_NARROW = 32
) (
  input  logic             sign,
  input  logic [WEXP-1:0]  exp_w,
  input  logic [WFRAC-1:0] frac_w,
  input  op_class_t        cls,
  input  rmode_e           mode,
  input  logic             int64_sel,
  output logic [WEXP-1:0]  r_exp,
  output logic [WFRAC-1:0] r_frac,
  output logic             r_zero,
  output logic             inexact,
  output logic             invalid
);
  localparam int SW = WFRAC + 1;
  localparam int EW = WEXP + 2;
  localparam logic signed [EW-1:0] LIM_WIDE   = EW'(INT_WIDE - 1);
  localparam logic signed [EW-1:0] LIM_NARROW = EW'(INT_NARROW - 1);
  localparam logic signed [EW-1:0] BIAS_S     = EW'(WBIAS);
  localparam logic signed [EW-1:0] FRAC_S     = EW'(WFRAC);

  logic signed [EW-1:0] e_unb;
  logic signed [EW-1:0] re_unb;
  logic signed [EW-1:0] lim;
  logic [SW-1:0]        sig;
  logic [SW-1:0]        mask;
  logic [SW-1:0]        kept;
  logic [SW:0]          sum;
  logic                 guard_b;
  logic                 sticky_b;
  logic                 lsb_b;
  logic                 inc;
  logic                 over;
  int                   fb;

  assign e_unb = $signed({2'b00, exp_w}) - BIAS_S;
  assign sig   = {1'b1, frac_w};
  assign lim   = int64_sel ? LIM_WIDE : LIM_NARROW;

  // locate the binary point and gather guard / sticky information
  always_comb begin
    fb       = 0;
    mask     = '0;
    kept     = sig;
    guard_b  = 1'b0;
    sticky_b = 1'b0;
    lsb_b    = 1'b0;
    if (cls.zero || cls.special || (e_unb >= FRAC_S)) begin
      kept = sig;
    end else if (e_unb >= 0) begin
      fb       = WFRAC - int'(e_unb);
      mask     = (SW'(1) << fb) - SW'(1);
      kept     = sig & ~mask;
      guard_b  = |(sig & (mask ^ (mask >> 1)));
      sticky_b = |(sig & (mask >> 1));
      lsb_b    = |(sig & (mask + SW'(1)));
    end else if (e_unb == -1) begin
      guard_b  = 1'b1;
      sticky_b = |frac_w;
    end else begin
      sticky_b = 1'b1;
    end
  end

  // increment decision per rounding direction
  always_comb begin
    case (mode)
      RM_NEAR_EVEN: inc = guard_b & (sticky_b | lsb_b);
      RM_UP:        inc = ~sign & (guard_b | sticky_b);
      RM_DOWN:      inc = sign & (guard_b | sticky_b);
      default:      inc = 1'b0;
    endcase
  end

  // rebuild the integral value, carry out of the significand bumps the exponent
  always_comb begin
    sum    = '0;
    r_exp  = exp_w;
    r_frac = frac_w;
    r_zero = 1'b0;
    if (cls.zero) begin
      r_zero = 1'b1;
    end else if (cls.special || (e_unb >= FRAC_S)) begin
      r_exp  = exp_w;
      r_frac = frac_w;
    end else if (e_unb >= 0) begin
      sum = {1'b0, kept} + (inc ? ({1'b0, mask} + (SW+1)'(1)) : '0);
      if (sum[SW]) begin
        r_exp  = exp_w + WEXP'(1);
        r_frac = '0;
      end else begin
        r_exp  = exp_w;
        r_frac = sum[WFRAC-1:0];
      end
    end else if (inc) begin
      r_exp  = WEXP'(WBIAS);
      r_frac = '0;
    end else begin
      r_zero = 1'b1;
    end
  end

  assign re_unb = $signed({2'b00, r_exp}) - BIAS_S;

  always_comb begin
    over = 1'b0;
    if (!r_zero) begin
      if (re_unb > lim) begin
        over = 1'b1;
      end else if (re_unb == lim) begin
        over = !(sign && (r_frac == '0));
      end
    end
    invalid = cls.special | over;
    inexact = (guard_b | sticky_b) & ~cls.zero & ~invalid;
  end
endmodule

// File: rtl/rbi_narrow.sv
module rbi_narrow
  import rbi_pkg::*;
#(
  parameter int WEXP       = DEXP,
  parameter int WFRAC      = DFRAC,
  parameter int WBIAS      = DBIAS,
  parameter int NEXP       = SEXP,
  parameter int NFRAC      = SFRAC,
  parameter int NBIAS      = SBIAS,
  parameter int INT_WIDE   = 64,
  parameter int INT_NARROW = 32
) (
  input  logic                is_single,
  input  logic                int64_sel,
  input  logic                sign,
  input  logic [WEXP-1:0]     r_exp,
  input  logic [WFRAC-1:0]    r_frac,
  input  logic                r_zero,
  input  logic                invalid,
  output logic [WEXP+WFRAC:0] res
);
  localparam int WW     = 1 + WEXP + WFRAC;
  localparam int NW     = 1 + NEXP + NFRAC;
  localparam int REBIAS = WBIAS - NBIAS;

  logic [WEXP-1:0] lim_w_exp;
  logic [NEXP-1:0] lim_n_exp;
  logic [NEXP-1:0] n_exp;

  assign lim_w_exp = int64_sel ? WEXP'(WBIAS + INT_WIDE - 1) : WEXP'(WBIAS + INT_NARROW - 1);
  assign lim_n_exp = int64_sel ? NEXP'(NBIAS + INT_WIDE - 1) : NEXP'(NBIAS + INT_NARROW - 1);
  assign n_exp     = NEXP'(r_exp - WEXP'(REBIAS));

  always_comb begin
    res = '0;
    if (is_single) begin
      if (invalid) begin
        res[NW-1:0] = {1'b1, lim_n_exp, {NFRAC{1'b0}}};
      end else if (r_zero) begin
        res[NW-1:0] = {sign, {(NW-1){1'b0}}};
      end else begin
        res[NW-1:0] = {sign, n_exp, r_frac[WFRAC-1 -: NFRAC]};
      end
    end else begin
      if (invalid) begin
        res = {1'b1, lim_w_exp, {WFRAC{1'b0}}};
      end else if (r_zero) begin
        res = {sign, {(WW-1){1'b0}}};
      end else begin
        res = {sign, r_exp, r_frac};
      end
    end
  end
endmodule

// File: rtl/fp_round_bounded.sv
module fp_round_bounded
  import rbi_pkg::*;
#(
  parameter int INT_WIDE   = 64,
  parameter int INT_NARROW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [WORD-1:0] op_bits,
  input  logic [1:0]      fmt_sel,
  input  logic            int64_sel,
  input  logic            use_dyn,
  input  logic [1:0]      dyn_mode,
  output logic            out_valid,
  output logic [WORD-1:0] result,
  output logic            inexact,
  output logic            invalid,
  output logic            undef
);
  logic rst_meta;
  logic rst_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic             is_single;
  logic             fmt_bad;
  rmode_e           mode;
  logic             w_sign;
  logic [DEXP-1:0]  w_exp;
  logic [DFRAC-1:0] w_frac;
  op_class_t        w_cls;
  logic [DEXP-1:0]  r_exp;
  logic [DFRAC-1:0] r_frac;
  logic             r_zero;
  logic             c_inexact;
  logic             c_invalid;
  logic [WORD-1:0]  c_res;

  assign is_single = (fmt_sel == 2'b00);
  assign fmt_bad   = fmt_sel[1];
  assign mode      = use_dyn ? rmode_e'(dyn_mode) : RM_ZERO;

  rbi_widen u_widen (
    .op_bits   (op_bits),
    .is_single (is_single),
    .sign      (w_sign),
    .exp_w     (w_exp),
    .frac_w    (w_frac),
    .cls       (w_cls)
  );

  rbi_round_core #(
    .INT_WIDE   (INT_WIDE),
    .INT_NARROW (INT_NARROW)
  ) u_core (
    .sign      (w_sign),
    .exp_w     (w_exp),
    .frac_w    (w_frac),
    .cls       (w_cls),
    .mode      (mode),
    .int64_sel (int64_sel),
    .r_exp     (r_exp),
    .r_frac    (r_frac),
    .r_zero    (r_zero),
    .inexact   (c_inexact),
    .invalid   (c_invalid)
  );

  rbi_narrow #(
    .INT_WIDE   (INT_WIDE),
    .INT_NARROW (INT_NARROW)
  ) u_narrow (
    .is_single (is_single),
    .int64_sel (int64_sel),
    .sign      (w_sign),
    .r_exp     (r_exp),
    .r_frac    (r_frac),
    .r_zero    (r_zero),
    .invalid   (c_invalid),
    .res       (c_res)
  );

  logic            valid_d;
  logic [WORD-1:0] res_d;
  logic            inexact_d;
  logic            invalid_d;
  logic            undef_d;

  always_comb begin
    valid_d   = in_valid;
    res_d     = fmt_bad ? '0 : c_res;
    inexact_d = c_inexact & ~fmt_bad;
    invalid_d = c_invalid & ~fmt_bad;
    undef_d   = fmt_bad;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      result    <= '0;
      inexact   <= 1'b0;
      invalid   <= 1'b0;
      undef     <= 1'b0;
    end else begin
      out_valid <= valid_d;
      if (in_valid) begin
        result  <= res_d;
        inexact <= inexact_d;
        invalid <= invalid_d;
        undef   <= undef_d;
      end
    end
  end
endmodule

// File: rtl/fp_round_bounded_chk.sv
module fp_round_bounded_chk (
  input logic        clk,
  input logic        rst_q,
  input logic        in_valid,
  input logic [63:0] op_bits,
  input logic [1:0]  fmt_sel,
  input logic        int64_sel,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        inexact,
  input logic        invalid,
  input logic        undef
);
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> $stable(result) && $stable(inexact) && $stable(invalid));

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> !(inexact && invalid));

  a_r1_undef: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid && $past(fmt_sel[1]) |-> undef && result == 64'd0 && !inexact && !invalid);

  a_r1_single_upper: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid && $past(fmt_sel) == 2'b00 |-> result[63:32] == 32'd0);

  a_r6_invalid_double: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid && invalid && $past(fmt_sel) == 2'b01 |->
      result == ($past(int64_sel) ? 64'hC3E0000000000000 : 64'hC1E0000000000000));

  a_r6_invalid_single: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid && invalid && $past(fmt_sel) == 2'b00 |->
      result == ($past(int64_sel) ? 64'h00000000DF000000 : 64'h00000000CF000000));

  a_r4_zero_double: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid && $past(fmt_sel) == 2'b01 && $past(op_bits[62:0]) == 63'd0 |->
      result == $past(op_bits) && !inexact && !invalid);
endmodule

bind fp_round_bounded fp_round_bounded_chk chk_i (
  .clk       (clk),
  .rst_q     (rst_q),
  .in_valid  (in_valid),
  .op_bits   (op_bits),
  .fmt_sel   (fmt_sel),
  .int64_sel (int64_sel),
  .out_valid (out_valid),
  .result    (result),
  .inexact   (inexact),
  .invalid   (invalid),
  .undef     (undef)
);

// File: tb/fp_round_bounded_tb_top.sv
`timescale 1ns/1ps
module fp_round_bounded_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] op_bits;
  logic [1:0]  fmt_sel;
  logic        int64_sel;
  logic        use_dyn;
  logic [1:0]  dyn_mode;
  logic        out_valid;
  logic [63:0] result;
  logic        inexact;
  logic        invalid;
  logic        undef;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  fp_round_bounded dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_bits   (op_bits),
    .fmt_sel   (fmt_sel),
    .int64_sel (int64_sel),
    .use_dyn   (use_dyn),
    .dyn_mode  (dyn_mode),
    .out_valid (out_valid),
    .result    (result),
    .inexact   (inexact),
    .invalid   (invalid),
    .undef     (undef)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] to_single(input logic [63:0] d);
    if (d[62:0] == 63'd0) return {32'd0, d[63], 31'd0};
    return {32'd0, d[63], 8'(d[62:52] - 11'd896), d[51:29]};
  endfunction

  function automatic bit single_exact(input real x);
    logic [63:0] d;
    d = $realtobits(x);
    if (d[62:0] == 63'd0) return 1'b1;
    return (d[62:52] >= 11'd897) && (d[62:52] <= 11'd1150) && (d[28:0] == 29'd0);
  endfunction

  function automatic real rne(input real x);
    real f, h;
    f = $floor(x);
    h = x - f;
    if (h > 0.5) return f + 1.0;
    if (h < 0.5) return f;
    if ($floor(f / 2.0) * 2.0 == f) return f;
    return f + 1.0;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp_v);
    n_chk++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp_v);
    end
  endtask

  // one operation; mode 4 means use_dyn low (truncation)
  task automatic run_op(input logic [1:0] fmt, input bit i64, input int md,
                        input logic [63:0] bits, input bit special, input bit sgn, input real x);
    real         lim, r;
    logic [63:0] e_res;
    bit          e_inx, e_inv;
    string       req;
    lim   = i64 ? 2.0**63 : 2.0**31;
    e_inx = 0;
    e_inv = 0;
    r     = 0.0;
    if (special) begin
      e_inv = 1;
      req   = "R6";
    end else begin
      case (md)
        0: r = rne(x);
        1: r = $ceil(x);
        2: r = $floor(x);
        default: r = (x < 0.0) ? $ceil(x) : $floor(x);
      endcase
      if (r >= lim || r < -lim) begin
        e_inv = 1;
        req   = "R7";
      end else if (x == 0.0) req = "R4";
      else if (r == 0.0) req = "R8";
      else if (r == x) req = "R9";
      else if (md == 4) req = "R2";
      else req = "R3";
    end
    if (e_inv) e_res = $realtobits(-lim);
    else if (r == 0.0) e_res = {sgn, 63'd0};
    else e_res = $realtobits(r);
    if (!e_inv) e_inx = (r != x);
    if (fmt == 2'b00) e_res = to_single(e_res);
    @(negedge clk);
    op_bits   = bits;
    fmt_sel   = fmt;
    int64_sel = i64;
    use_dyn   = (md != 4);
    dyn_mode  = (md == 4) ? 2'(md - 1) : 2'(md);
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
    n_chk++;
    if (result !== e_res || inexact !== e_inx || invalid !== e_inv || out_valid !== 1'b1 || undef !== 1'b0) begin
      n_fail++;
      $display("FAIL %s/R5/R10 op=%h fmt=%b i64=%0d md=%0d: got res=%h inx=%0d inv=%0d v=%0d expected res=%h inx=%0d inv=%0d v=1",
               req, bits, fmt, i64, md, result, inexact, invalid, out_valid, e_res, e_inx, e_inv);
    end
  endtask

  task automatic sweep_val(input real x);
    logic [63:0] d;
    d = $realtobits(x);
    for (int i = 0; i < 2; i++) begin
      for (int md = 0; md < 5; md++) begin
        run_op(2'b01, i[0], md, d, 1'b0, d[63], x);
        if (single_exact(x)) run_op(2'b00, i[0], md, to_single(d), 1'b0, d[63], x);
      end
    end
  endtask

  task automatic sweep_raw(input logic [1:0] fmt, input logic [63:0] bits, input bit special,
                           input bit sgn, input real x);
    for (int i = 0; i < 2; i++)
      for (int md = 0; md < 5; md++)
        run_op(fmt, i[0], md, bits, special, sgn, x);
  endtask

  initial begin
    real vals[$];
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    op_bits   = '0;
    fmt_sel   = 2'b01;
    int64_sel = 1'b0;
    use_dyn   = 1'b0;
    dyn_mode  = 2'b00;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 out_valid", {63'd0, out_valid}, 64'd0);
    check("R11 result", result, 64'd0);
    check("R11 flags", {61'd0, inexact, invalid, undef}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 after release", {60'd0, out_valid, inexact, invalid, undef}, 64'd0);

    for (int k = -40; k <= 40; k++) vals.push_back(k / 4.0);
    vals.push_back(-0.0);
    vals.push_back(0.5 + 2.0**-30);
    vals.push_back(0.5 - 2.0**-30);
    vals.push_back(2.5 + 2.0**-20);
    vals.push_back(-2.5 - 2.0**-20);
    vals.push_back(-1.5 + 2.0**-20);
    vals.push_back(1.0 + 2.0**-52);
    vals.push_back(2.0**31 - 1.0);
    vals.push_back(2.0**31 - 0.5);
    vals.push_back(2.0**31 - 1.5);
    vals.push_back(2.0**31);
    vals.push_back(-(2.0**31));
    vals.push_back(-(2.0**31) - 0.5);
    vals.push_back(-(2.0**31) - 1.0);
    vals.push_back(-(2.0**31) + 0.5);
    vals.push_back(2147483520.0);
    vals.push_back(-2147483904.0);
    vals.push_back(2.0**63);
    vals.push_back(-(2.0**63));
    vals.push_back(2.0**63 - 1024.0);
    vals.push_back(-(2.0**63) - 2048.0);
    vals.push_back(2.0**62);
    vals.push_back(2.0**52 + 1.0);
    vals.push_back(2.0**52 - 0.5);
    vals.push_back(2.0**53);
    vals.push_back(1.0e300);
    vals.push_back(-1.0e300);
    foreach (vals[i]) sweep_val(vals[i]);

    // R8 denormals
    sweep_raw(2'b01, 64'h0000000000000001, 1'b0, 1'b0, $bitstoreal(64'h0000000000000001));
    sweep_raw(2'b01, 64'h800FFFFFFFFFFFFF, 1'b0, 1'b1, $bitstoreal(64'h800FFFFFFFFFFFFF));
    sweep_raw(2'b00, 64'h0000000000000001, 1'b0, 1'b0, 2.0**-149);
    sweep_raw(2'b00, 64'h0000000080400000, 1'b0, 1'b1, -(2.0**-127));
    // R6 NaN and infinity
    sweep_raw(2'b01, 64'h7FF8000000000000, 1'b1, 1'b0, 0.0);
    sweep_raw(2'b01, 64'h7FF0000000000001, 1'b1, 1'b0, 0.0);
    sweep_raw(2'b01, 64'hFFF0000000000000, 1'b1, 1'b1, 0.0);
    sweep_raw(2'b01, 64'h7FF0000000000000, 1'b1, 1'b0, 0.0);
    sweep_raw(2'b00, 64'h000000007FC00000, 1'b1, 1'b0, 0.0);
    sweep_raw(2'b00, 64'h000000007F800001, 1'b1, 1'b0, 0.0);
    sweep_raw(2'b00, 64'h00000000FF800000, 1'b1, 1'b1, 0.0);
    sweep_raw(2'b00, 64'h000000007F800000, 1'b1, 1'b0, 0.0);

    // R1 illegal format selects
    for (int f = 2; f < 4; f++) begin
      @(negedge clk);
      op_bits  = 64'h7FF0000000000000;
      fmt_sel  = 2'(f);
      use_dyn  = 1'b1;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 undef", {61'd0, undef, inexact, invalid}, 64'd4);
      check("R1 undef result", result, 64'd0);
    end

    // R10 idle cycle: valid falls, result held
    @(negedge clk);
    check("R10 idle valid", {63'd0, out_valid}, 64'd0);
    check("R10 idle hold", result, 64'd0);
    op_bits = 64'h4004000000000000;
    fmt_sel = 2'b01;
    @(negedge clk);
    check("R10 no capture", result, 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule